// File: doc/BRIEF.md
# Sturdy MASH 2-1 Delta-Sigma Modulator

This block is the all-digital noise shaper that sits between an oversampling interpolator and a unit-element DAC. Each enabled clock it takes one signed 25-bit sample and emits one of nine output levels. The levels are meant to be decoded into a thermometer code that drives eight equal unit cells. The main loop is a second-order chain of two integrators. A small resonator feedback from the second integrator into the first moves the noise zeros from DC up to the edge of the signal band. The quantization error of the first loop's nine-level quantizer goes into a first-order error-feedback stage. The sum of both stages' decisions is what the first loop subtracts, so the first stage's error never reaches the output and no cancellation network is needed.

A trailing one-pole low-pass filter smooths the same level stream. It gives a fixed-point copy with less high-frequency content. All states are two's-complement fixed point, and each one saturates at its own width instead of wrapping. One output level step corresponds to 2^LSB_SH input codes.

Top module: `sturdy_mash21`

## Requirements
- R1: While reset is asserted, the level output is code 4 and the filtered output is 0.
- R2: When the clock enable is low, both outputs hold and the input sample is ignored. The code sequence seen on enabled cycles is the same as it would be with no pauses.
- R3: The level output is an unsigned code from 0 to 8, equal to the signed level plus 4, with code 4 meaning zero. The second stage adds a correction of -1, 0 or +1 level. While that correction is not clipped, the residue it carries stays within half a level.
- R4: With a zero input from reset, every enabled cycle yields code 4.
- R5: For a constant input d with |d| up to half of full scale, the mean of (code - 4) over 4096 enabled cycles is within 0.01 of d / 2^22.
- R6: For a slow sine of amplitude 1.6 levels and period 2048 samples, the mean of (code - 4) over each 128-sample window is within 0.1 of the mean of input / 2^22 over the same window.
- R7: The filtered output is a signed level with 8 fractional bits. It never exceeds ±4.0 levels. Each enabled step moves it toward the current level and never past it. Under a constant input, its window mean matches the mean of (code - 4) within 0.05 level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce | input | 1 | Sample enable; one modulator step per high cycle |
| din | input | IN_W (25) | Signed input sample; 2^22 per output level |
| lvl_o | output | 4 | Output code 0..8 (level + 4) |
| flt_o | output | FLT_W (13) | Filtered level, signed, 8 fractional bits |

## Verification
A zero input from reset must give a constant mid-scale code. That separates a clean idle path from one that drifts because of rounding bias. Constant inputs at several levels, including one below a single output step and one negative, test whether the long-run level average matches the input. That exposes errors in feedback scaling, sign or resonator strength. A slow sine, averaged over short windows, shows that the loop follows a moving input rather than only a DC one. Enable patterns with gaps, fed with a conflicting input during the gaps, show that the states freeze and that the sample is ignored.

// File: rtl/smash_pkg.sv
package smash_pkg;
  typedef logic signed [3:0] lvl_t;

  localparam int LVL_MAX = 4;

  function automatic lvl_t clamp_lvl(input logic signed [31:0] a, input int lim);
    if (a > lim) return lvl_t'(lim);
    if (a < -lim) return lvl_t'(-lim);
    return lvl_t'(a);
  endfunction

  function automatic logic [3:0] lvl_to_code(input lvl_t l);
    return 4'(l + 4'sd4);
  endfunction
endpackage

// File: rtl/dsm_res_loop.sv
module dsm_res_loop
  import smash_pkg::*;
#(
  parameter int IN_W   = 25,
  parameter int ST_W   = 30,
  parameter int LSB_SH = 22,
  parameter int RES_SH = 11
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ce,
  input  logic signed [IN_W-1:0] din,
  input  lvl_t                   v_lvl,
  output logic signed [ST_W-1:0] s2_q
);
  localparam int WW = ST_W + 2;
  localparam logic signed [WW-1:0] ST_HI = {3'b000, {(ST_W-1){1'b1}}};
  localparam logic signed [WW-1:0] ST_LO = {3'b111, {(ST_W-1){1'b0}}};

  function automatic logic signed [ST_W-1:0] clip(input logic signed [WW-1:0] a);
    if (a > ST_HI) return ST_HI[ST_W-1:0];
    if (a < ST_LO) return ST_LO[ST_W-1:0];
    return a[ST_W-1:0];
  endfunction

  logic signed [ST_W-1:0] s1_q, s1_nx, s2_nx;
  logic signed [WW-1:0]   din_x, fb_x, res_x, s1_x, s2_x, s1n_x, s1_sum, s2_sum;

  assign din_x  = WW'(din);
  assign fb_x   = WW'(v_lvl) <<< LSB_SH;
  assign s1_x   = WW'(s1_q);
  assign s2_x   = WW'(s2_q);
  assign res_x  = s2_x >>> RES_SH;
  assign s1_sum = s1_x + din_x - fb_x - res_x;
  assign s1_nx  = clip(s1_sum);
  assign s1n_x  = WW'(s1_nx);
  assign s2_sum = s2_x + s1n_x - fb_x;
  assign s2_nx  = clip(s2_sum);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else if (ce) begin
      s1_q <= s1_nx;
      s2_q <= s2_nx;
    end
  end
endmodule

// File: rtl/dsm_err_stage.sv
module dsm_err_stage
  import smash_pkg::*;
#(
  parameter int ST_W   = 30,
  parameter int LSB_SH = 22
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ce,
  input  logic signed [ST_W-1:0] s2_q,
  output lvl_t                   v_lvl,
  output logic                   v2_clip,
  output logic signed [ST_W-1:0] res_q
);
  localparam int WW = ST_W + 2;
  localparam logic signed [WW-1:0] ST_HI  = {3'b000, {(ST_W-1){1'b1}}};
  localparam logic signed [WW-1:0] ST_LO  = {3'b111, {(ST_W-1){1'b0}}};
  localparam logic signed [WW-1:0] HALF_X = WW'(1) <<< (LSB_SH - 1);

  function automatic logic signed [ST_W-1:0] clip(input logic signed [WW-1:0] a);
    if (a > ST_HI) return ST_HI[ST_W-1:0];
    if (a < ST_LO) return ST_LO[ST_W-1:0];
    return a[ST_W-1:0];
  endfunction

  function automatic logic signed [WW-1:0] round_lvl(input logic signed [WW-1:0] a);
    return (a + HALF_X) >>> LSB_SH;
  endfunction

  lvl_t                   v1, v2;
  logic signed [31:0]     q1_32, q2_32;
  logic signed [WW-1:0]   s2_x, r_x, e1_x, u2_x, rn_x;
  logic signed [ST_W-1:0] res_nx;

  assign s2_x    = WW'(s2_q);
  assign r_x     = WW'(res_q);
  assign q1_32   = 32'(round_lvl(s2_x));
  assign v1      = clamp_lvl(q1_32, LVL_MAX);
  assign e1_x    = s2_x - (WW'(v1) <<< LSB_SH);
  assign u2_x    = e1_x + r_x;
  assign q2_32   = 32'(round_lvl(u2_x));
  assign v2      = clamp_lvl(q2_32, 1);
  assign v2_clip = (q2_32 > 1) || (q2_32 < -1);
  assign rn_x    = u2_x - (WW'(v2) <<< LSB_SH);
  assign res_nx  = clip(rn_x);
  assign v_lvl   = clamp_lvl(32'(v1) + 32'(v2), LVL_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_q <= '0;
    else if (ce) res_q <= res_nx;
  end
endmodule

// File: rtl/dsm_pole_lpf.sv
module dsm_pole_lpf
  import smash_pkg::*;
#(
  parameter int FLT_W   = 13,
  parameter int FRAC_W  = 8,
  parameter int POLE_SH = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ce,
  input  lvl_t                    v_lvl,
  output logic signed [FLT_W-1:0] y_q
);
  localparam int GW = FLT_W + 1;

  logic signed [FLT_W-1:0] tgt;
  logic signed [GW-1:0]    gap, step;

  assign tgt  = FLT_W'(v_lvl) <<< FRAC_W;
  assign gap  = GW'(tgt) - GW'(y_q);
  assign step = gap >>> POLE_SH;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) y_q <= '0;
    else if (ce) y_q <= y_q + FLT_W'(step);
  end
endmodule

// File: rtl/sturdy_mash21.sv
module sturdy_mash21
  import smash_pkg::*;
#(
  parameter int IN_W    = 25,
  parameter int ST_W    = 30,
  parameter int LSB_SH  = 22,
  parameter int RES_SH  = 11,
  parameter int FRAC_W  = 8,
  parameter int POLE_SH = 3,
  parameter int FLT_W   = FRAC_W + 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ce,
  input  logic signed [IN_W-1:0]  din,
  output logic [3:0]              lvl_o,
  output logic signed [FLT_W-1:0] flt_o
);
  lvl_t                   v_now;
  logic                   v2_clip;
  logic signed [ST_W-1:0] s2_q, res_q;

  dsm_res_loop #(
    .IN_W(IN_W), .ST_W(ST_W), .LSB_SH(LSB_SH), .RES_SH(RES_SH)
  ) u_loop (
    .clk(clk), .rst_n(rst_n), .ce(ce), .din(din), .v_lvl(v_now), .s2_q(s2_q)
  );

  dsm_err_stage #(
    .ST_W(ST_W), .LSB_SH(LSB_SH)
  ) u_err (
    .clk(clk), .rst_n(rst_n), .ce(ce), .s2_q(s2_q),
    .v_lvl(v_now), .v2_clip(v2_clip), .res_q(res_q)
  );

  dsm_pole_lpf #(
    .FLT_W(FLT_W), .FRAC_W(FRAC_W), .POLE_SH(POLE_SH)
  ) u_lpf (
    .clk(clk), .rst_n(rst_n), .ce(ce), .v_lvl(v_now), .y_q(flt_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_o <= 4'd4;
    else if (ce) lvl_o <= lvl_to_code(v_now);
  end
endmodule

// File: rtl/smash_chk.sv
module smash_chk
  import smash_pkg::*;
#(
  parameter int ST_W   = 30,
  parameter int LSB_SH = 22,
  parameter int FLT_W  = 13,
  parameter int FRAC_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    ce,
  input logic [3:0]              lvl_o,
  input logic signed [FLT_W-1:0] flt_o,
  input lvl_t                    v_now,
  input logic signed [ST_W-1:0]  res_q,
  input logic                    v2_clip
);
  localparam logic signed [ST_W-1:0]  HALF_C  = ST_W'(1) <<< (LSB_SH - 1);
  localparam logic signed [FLT_W-1:0] FLT_LIM = FLT_W'(4) <<< FRAC_W;

  logic signed [FLT_W-1:0] tgt_c;
  assign tgt_c = FLT_W'(v_now) <<< FRAC_W;

  p_code_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_o <= 4'd8);

  p_resid_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !v2_clip) |=> ((res_q <= HALF_C) && (res_q >= -HALF_C)));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> ($stable(lvl_o) && $stable(flt_o)));

  p_flt_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && (tgt_c > flt_o)) |=> (flt_o >= $past(flt_o)));

  p_flt_dn_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && (tgt_c < flt_o)) |=> (flt_o <= $past(flt_o)));

  p_flt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_o <= FLT_LIM) && (flt_o >= -FLT_LIM));
endmodule

bind sturdy_mash21 smash_chk #(
  .ST_W(ST_W), .LSB_SH(LSB_SH), .FLT_W(FLT_W), .FRAC_W(FRAC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ce(ce), .lvl_o(lvl_o), .flt_o(flt_o),
  .v_now(v_now), .res_q(res_q), .v2_clip(v2_clip)
);

// File: tb/sturdy_mash21_tb.sv
module sturdy_mash21_tb;
  localparam int  CLK_NS  = 10;
  localparam int  IN_W    = 25;
  localparam int  FLT_W   = 13;
  localparam real LVL_Q   = 4194304.0;
  localparam real FRAC_S  = 256.0;
  localparam int  WD_CYC  = 100000;
  localparam int  PAUSE_N = 300;

  typedef struct {
    string tag;
    real   exp_mean;
    real   tol;
    int    n;
    bit    chk_flt;
  } exp_t;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    ce = 1'b0;
  logic                    meas = 1'b0;
  logic signed [IN_W-1:0]  din = '0;
  logic [3:0]              lvl_o;
  logic signed [FLT_W-1:0] flt_o;

  int   n_chk = 0;
  int   n_fail = 0;
  int   max_code = 0;
  int   max_flt = 0;
  int   min_flt = 0;
  int   cnt = 0;
  real  acc = 0.0;
  real  facc = 0.0;
  exp_t cur;
  exp_t sb_q[$];

  sturdy_mash21 u_dut (
    .clk(clk), .rst_n(rst_n), .ce(ce), .din(din), .lvl_o(lvl_o), .flt_o(flt_o)
  );

  always #(CLK_NS / 2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input real act, input real exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %f expected %f", req, what, act, exp_v);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  task automatic drive(input logic c, input logic signed [IN_W-1:0] d, input logic m);
    @(negedge clk);
    ce = c;
    din = d;
    meas = m;
  endtask

  task automatic cyc_s(input logic c, input logic signed [IN_W-1:0] d,
                       output logic [3:0] code);
    drive(c, d, 1'b0);
    @(posedge clk);
    #2;
    code = lvl_o;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    ce = 1'b0;
    din = '0;
    meas = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic signed [IN_W-1:0] sine_at(input int n);
    real a;
    a = 6710886.0 * $sin(2.0 * 3.14159265358979 * real'(n) / 2048.0);
    return IN_W'($rtoi(a));
  endfunction

  // monitor: pops one expected window per measured run and compares
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      if (int'(lvl_o) > max_code) max_code = int'(lvl_o);
      if (int'(flt_o) > max_flt) max_flt = int'(flt_o);
      if (int'(flt_o) < min_flt) min_flt = int'(flt_o);
    end
    if (meas) begin
      if (cnt == 0) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R5", "window without expectation", 0.0, 1.0);
          cur.n = 1; cur.tag = "R5"; cur.exp_mean = 0.0; cur.tol = 0.0; cur.chk_flt = 0;
        end else begin
          cur = sb_q.pop_front();
        end
        acc = 0.0;
        facc = 0.0;
      end
      acc  = acc + real'(int'(lvl_o)) - 4.0;
      facc = facc + real'(flt_o) / FRAC_S;
      cnt++;
      if (cnt == cur.n) begin
        chk((acc / cur.n - cur.exp_mean <= cur.tol) && (cur.exp_mean - acc / cur.n <= cur.tol),
            cur.tag, "window level mean", acc / cur.n, cur.exp_mean);
        if (cur.chk_flt)
          chk((facc - acc) / cur.n <= 0.05 && (acc - facc) / cur.n <= 0.05,
              "R7", "filtered mean vs level mean", facc / cur.n, acc / cur.n);
        cnt = 0;
      end
    end
  end

  // driver for constant inputs (R5, R7)
  task automatic run_dc(input logic signed [IN_W-1:0] d);
    exp_t it;
    for (int i = 0; i < 512; i++) drive(1'b1, d, 1'b0);
    it.tag = "R5";
    it.exp_mean = real'(d) / LVL_Q;
    it.tol = 0.01;
    it.n = 4096;
    it.chk_flt = 1'b1;
    sb_q.push_back(it);
    for (int i = 0; i < 4096; i++) drive(1'b1, d, 1'b1);
    drive(1'b1, d, 1'b0);
  endtask

  // driver for the slow sine (R6)
  task automatic run_sine();
    exp_t it;
    real  s;
    for (int n = 0; n < 1024; n++) drive(1'b1, sine_at(n), 1'b0);
    for (int k = 0; k < 8; k++) begin
      s = 0.0;
      for (int i = 0; i < 128; i++) s = s + real'(sine_at(1024 + k * 128 + i));
      it.tag = "R6";
      it.exp_mean = s / 128.0 / LVL_Q;
      it.tol = 0.1;
      it.n = 128;
      it.chk_flt = 1'b0;
      sb_q.push_back(it);
      for (int i = 0; i < 128; i++) drive(1'b1, sine_at(1024 + k * 128 + i), 1'b1);
    end
    drive(1'b1, '0, 1'b0);
  endtask

  initial begin : watchdog
    repeat (WD_CYC) @(posedge clk);
    chk(1'b0, "all", "watchdog cycles", real'(WD_CYC), 0.0);
    summary();
  end

  initial begin : main
    logic [3:0] code;
    logic [3:0] last;
    logic [3:0] ref_c [PAUSE_N];
    int         bad;
    int         hold_bad;
    logic signed [IN_W-1:0] dp;

    // R1: reset values, sampled while reset is held
    @(negedge clk);
    #1;
    chk(lvl_o == 4'd4, "R1", "level code in reset", real'(lvl_o), 4.0);
    chk(flt_o == '0, "R1", "filter in reset", real'(flt_o), 0.0);
    do_reset();

    // R4: zero input idles at code 4
    bad = 0;
    for (int i = 0; i < 64; i++) begin
      cyc_s(1'b1, '0, code);
      if (code != 4'd4 || flt_o != '0) bad++;
    end
    chk(bad == 0, "R4", "non-mid codes on zero input", real'(bad), 0.0);

    // R5 / R7: constant inputs
    run_dc(25'sd4194304);
    run_dc(-25'sd5033165);
    run_dc(25'sd7549747);
    run_dc(25'sd65536);

    // R6: slow sine
    do_reset();
    run_sine();

    // R2: pauses freeze state and ignore the input
    dp = 25'sd5033165;
    do_reset();
    for (int i = 0; i < PAUSE_N; i++) begin
      cyc_s(1'b1, dp, code);
      ref_c[i] = code;
    end
    do_reset();
    bad = 0;
    hold_bad = 0;
    last = 4'd4;
    for (int i = 0; i < PAUSE_N; i++) begin
      if (i % 3 == 2) begin
        cyc_s(1'b0, -dp, code);
        if (code != last) hold_bad++;
      end
      cyc_s(1'b1, dp, code);
      if (code != ref_c[i]) bad++;
      last = code;
    end
    chk(hold_bad == 0, "R2", "output changes while paused", real'(hold_bad), 0.0);
    chk(bad == 0, "R2", "enabled codes differing from unpaused run", real'(bad), 0.0);

    // R3 / R7: range over the whole run
    chk(max_code <= 8, "R3", "largest code seen", real'(max_code), 8.0);
    chk(max_flt <= 1024 && min_flt >= -1024, "R7", "filter peak magnitude",
        real'((max_flt > -min_flt) ? max_flt : -min_flt), 1024.0);
    chk(sb_q.size() == 0, "R5", "unconsumed expected windows", real'(sb_q.size()), 0.0);

    summary();
  end
endmodule